// File: doc/BRIEF.md
# Banked RAM/ROM Memory Mapper

This block turns a 16-bit CPU address into a physical memory selection. The address space is cut into four 16 KB slots by its top two bits. Each slot is backed by one of eight 16 KB RAM banks, chosen by a 3-bit bank layout held in the block. The first slot and the last slot can also have a ROM laid over them. While a ROM is laid over a slot, reads come from that ROM and writes still reach the RAM bank underneath.

For every address the block returns three things. It gives the RAM bank that a write to that address reaches, and the 14-bit offset inside the 16 KB page. It also gives a 2-bit code that tells the read data path where to fetch from. The lookup is registered, so the result appears one clock after the address. The layout, both overlay flags and an 8-bit upper-ROM selector are captured together on a load strobe.

A static strap picks the full model or a base model. The base model has no banking and cannot reach the disk ROM.

Top module: `bank_mapper`

## Requirements
- R1: After reset the bank layout is 0 and both overlays are active. With no load made, address 0x0000 reads from the OS ROM with bank 0, and address 0xC000 reads from the BASIC ROM with bank 3. The output register holds bank 0, offset 0 and source OS while in reset.
- R2: In the full model, layout L (0..7) sends slots 0,1,2,3 to these banks:
  - L0 = {0,1,2,3}
  - L1 = {0,1,2,7}
  - L2 = {4,5,6,7}
  - L3 = {0,3,2,7}
  - L4 = {0,4,2,3}
  - L5 = {0,5,2,3}
  - L6 = {0,6,2,3}
  - L7 = {0,7,2,3}
  
  The slot is given by address bits [15:14].
- R3: Only bits [2:0] of the 8-bit layout input are used. Layouts that differ only in bits [7:3] give identical results.
- R4: When the strap `banked_i` is 0, the layout in use is 0 whatever was loaded. Each slot then maps to the bank of the same number.
- R5: In slot 0 the source is OS ROM when the lower overlay is active and RAM otherwise. The bank output is the layout's RAM bank in both cases.
- R6: In slot 3 the source is an upper ROM when the upper overlay is active and RAM otherwise. The bank output is the layout's RAM bank in both cases.
- R7: In the full model, an upper-ROM selector equal to 7 across all 8 bits picks the disk ROM. Any other value picks the BASIC ROM. In the base model the BASIC ROM is always picked.
- R8: Slots 1 and 2 always read from RAM, whatever the overlay flags are.
- R9: Source codes are 0 for RAM, 1 for OS ROM, 2 for BASIC ROM and 3 for disk ROM. The offset output equals address bits [13:0]. All outputs reflect the address present at the previous rising clock edge.
- R10: The layout, overlay flags and selector change only on a clock edge where `cfg_load_i` is 1. Changing those inputs while the strobe is 0 has no effect on the lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| banked_i | input | 1 | Static strap: 1 selects the full model, 0 the base model |
| cfg_load_i | input | 1 | Captures the layout, overlay flags and selector |
| ram_cfg_i | input | 8 | Bank layout; only bits [2:0] are used |
| lo_rom_map_i | input | 1 | 1 lays the OS ROM over slot 0 for reads |
| hi_rom_map_i | input | 1 | 1 lays an upper ROM over slot 3 for reads |
| rom_sel_i | input | 8 | Upper-ROM selector |
| addr_i | input | 16 | CPU address |
| bank_o | output | 3 | RAM bank for this address (the write target) |
| offset_o | output | 14 | Offset inside the 16 KB page |
| src_o | output | 2 | Read source code |

## Verification
The hardest case to reach is one where the bank and the read source disagree. That happens in a slot covered by an overlay under a layout that remaps it. The best example is layout 2 with slot 3 overlaid, where the bank is 7 but the source is a ROM.

The stimulus reaches it by loading every combination of model, layout, overlay flags and selector. This includes layout values with high bits set and selectors that match 7 only in their low bits. After each load, addresses at both ends and in the middle of every slot are applied. A directed step changes the configuration inputs without the strobe and confirms that the lookups are unchanged.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;
    localparam int NUM_SLOTS = 4;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);
    localparam int NUM_BANKS = 8;
    localparam int BANK_W    = $clog2(NUM_BANKS);
    localparam int NUM_LAYOUTS = 8;
    localparam int LAYOUT_W  = $clog2(NUM_LAYOUTS);

    typedef enum logic [1:0] {
        SRC_RAM   = 2'd0,
        SRC_OS    = 2'd1,
        SRC_BASIC = 2'd2,
        SRC_DISK  = 2'd3
    } rd_src_e;

    typedef logic [NUM_SLOTS-1:0][BANK_W-1:0] slot_banks_t;
    typedef rd_src_e [NUM_SLOTS-1:0] slot_srcs_t;
endpackage

// File: rtl/bankmap_table.sv
module bankmap_table
    import bankmap_pkg::*;
(
    input  logic [LAYOUT_W-1:0] layout_i,
    output slot_banks_t         banks_o
);
    // Fixed layout table, slot 0 in the least significant entry.
    always_comb begin
        case (layout_i)
            3'd0:    banks_o = {3'd3, 3'd2, 3'd1, 3'd0};
            3'd1:    banks_o = {3'd7, 3'd2, 3'd1, 3'd0};
            3'd2:    banks_o = {3'd7, 3'd6, 3'd5, 3'd4};
            3'd3:    banks_o = {3'd7, 3'd2, 3'd3, 3'd0};
            3'd4:    banks_o = {3'd3, 3'd2, 3'd4, 3'd0};
            3'd5:    banks_o = {3'd3, 3'd2, 3'd5, 3'd0};
            3'd6:    banks_o = {3'd3, 3'd2, 3'd6, 3'd0};
            default: banks_o = {3'd3, 3'd2, 3'd7, 3'd0};
        endcase
    end
endmodule

// File: rtl/bankmap_src.sv
module bankmap_src
    import bankmap_pkg::*;
#(
    parameter int                SEL_W    = 8,
    parameter logic [SEL_W-1:0]  DISK_SEL = SEL_W'(7)
) (
    input  logic             banked_i,
    input  logic             lo_map_i,
    input  logic             hi_map_i,
    input  logic [SEL_W-1:0] sel_i,
    output slot_srcs_t       srcs_o
);
    logic    disk_pick;
    rd_src_e upper_rom;

    assign disk_pick = banked_i && (sel_i == DISK_SEL);
    assign upper_rom = disk_pick ? SRC_DISK : SRC_BASIC;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        if (s == 0) begin : g_low
            assign srcs_o[s] = lo_map_i ? SRC_OS : SRC_RAM;
        end else if (s == NUM_SLOTS - 1) begin : g_high
            assign srcs_o[s] = hi_map_i ? upper_rom : SRC_RAM;
        end else begin : g_mid
            assign srcs_o[s] = SRC_RAM;
        end
    end
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
    import bankmap_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter int                CFG_W    = 8,
    parameter int                SEL_W    = 8,
    parameter logic [SEL_W-1:0]  DISK_SEL = SEL_W'(7)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              banked_i,
    input  logic              cfg_load_i,
    input  logic [CFG_W-1:0]  ram_cfg_i,
    input  logic              lo_rom_map_i,
    input  logic              hi_rom_map_i,
    input  logic [SEL_W-1:0]  rom_sel_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [BANK_W-1:0] bank_o,
    output logic [ADDR_W-SLOT_W-1:0] offset_o,
    output logic [1:0]        src_o
);
    localparam int OFFS_W = ADDR_W - SLOT_W;

    typedef struct packed {
        logic [LAYOUT_W-1:0] layout;
        logic                lo_map;
        logic                hi_map;
        logic [SEL_W-1:0]    sel;
    } cfg_t;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [OFFS_W-1:0] offs;
        rd_src_e           src;
    } look_t;

    typedef struct packed {
        cfg_t  cfg;
        look_t look;
    } state_t;

    state_t state_d, state_q;

    logic [SLOT_W-1:0]   slot;
    logic [LAYOUT_W-1:0] eff_layout;
    slot_banks_t         banks;
    slot_srcs_t          srcs;
    logic                unused_cfg_hi;

    assign slot          = addr_i[ADDR_W-1 -: SLOT_W];
    assign eff_layout    = banked_i ? state_q.cfg.layout : '0;
    assign unused_cfg_hi = ^ram_cfg_i[CFG_W-1:LAYOUT_W];

    bankmap_table u_table (
        .layout_i (eff_layout),
        .banks_o  (banks)
    );

    bankmap_src #(
        .SEL_W    (SEL_W),
        .DISK_SEL (DISK_SEL)
    ) u_src (
        .banked_i (banked_i),
        .lo_map_i (state_q.cfg.lo_map),
        .hi_map_i (state_q.cfg.hi_map),
        .sel_i    (state_q.cfg.sel),
        .srcs_o   (srcs)
    );

    always_comb begin
        state_d = state_q;
        if (cfg_load_i) begin
            state_d.cfg.layout = ram_cfg_i[LAYOUT_W-1:0];
            state_d.cfg.lo_map = lo_rom_map_i;
            state_d.cfg.hi_map = hi_rom_map_i;
            state_d.cfg.sel    = rom_sel_i;
        end
        state_d.look.bank = banks[slot];
        state_d.look.offs = addr_i[OFFS_W-1:0];
        state_d.look.src  = srcs[slot];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.cfg.layout <= '0;
            state_q.cfg.lo_map <= 1'b1;
            state_q.cfg.hi_map <= 1'b1;
            state_q.cfg.sel    <= '0;
            state_q.look.bank  <= '0;
            state_q.look.offs  <= '0;
            state_q.look.src   <= SRC_OS;
        end else begin
            state_q <= state_d;
        end
    end

    assign bank_o   = state_q.look.bank;
    assign offset_o = state_q.look.offs;
    assign src_o    = state_q.look.src;

    // R8
    mid_slot_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == SLOT_W'(1) || slot == SLOT_W'(2)) |=> (src_o == SRC_RAM));

    // R9
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (offset_o == $past(addr_i[OFFS_W-1:0])));

    // R4
    base_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !banked_i |=> (bank_o == BANK_W'($past(slot))));

    // R5
    low_ram_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == '0 && !state_q.cfg.lo_map) |=> (src_o == SRC_RAM));

    // R7
    disk_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (banked_i && slot == '1 && state_q.cfg.hi_map && state_q.cfg.sel == DISK_SEL)
        |=> (src_o == SRC_DISK));

    // R2
    layout2_slot1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (banked_i && slot == SLOT_W'(1) && state_q.cfg.layout == 3'd2)
        |=> (bank_o == 3'd5));

    // R10
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load_i |=> $stable(state_q.cfg));
endmodule

// File: tb/bank_mapper_tb.sv
module bank_mapper_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        banked_i = 1'b1;
    logic        cfg_load_i = 1'b0;
    logic [7:0]  ram_cfg_i = '0;
    logic        lo_rom_map_i = 1'b0;
    logic        hi_rom_map_i = 1'b0;
    logic [7:0]  rom_sel_i = '0;
    logic [15:0] addr_i = '0;
    logic [2:0]  bank_o;
    logic [13:0] offset_o;
    logic [1:0]  src_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    bank_mapper u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .banked_i     (banked_i),
        .cfg_load_i   (cfg_load_i),
        .ram_cfg_i    (ram_cfg_i),
        .lo_rom_map_i (lo_rom_map_i),
        .hi_rom_map_i (hi_rom_map_i),
        .rom_sel_i    (rom_sel_i),
        .addr_i       (addr_i),
        .bank_o       (bank_o),
        .offset_o     (offset_o),
        .src_o        (src_o)
    );

    function automatic int exp_bank(input int lay, input int slot);
        case (slot)
            0:       return (lay == 2) ? 4 : 0;
            1:       return (lay == 0 || lay == 1) ? 1 : (lay == 2) ? 5 : lay;
            2:       return (lay == 2) ? 6 : 2;
            default: return (lay >= 1 && lay <= 3) ? 7 : 3;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic load(input logic [7:0] c, input logic lo, input logic hi, input logic [7:0] s);
        @(negedge clk);
        ram_cfg_i = c; lo_rom_map_i = lo; hi_rom_map_i = hi; rom_sel_i = s;
        cfg_load_i = 1'b1;
        @(negedge clk);
        cfg_load_i = 1'b0;
    endtask

    task automatic look(input logic [15:0] a);
        addr_i = a;
        @(negedge clk);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] sels [5] = '{8'h00, 8'h06, 8'h07, 8'h87, 8'hFF};
        repeat (3) @(negedge clk);
        // R1: output register while in reset
        chk("R1 reset bank", int'(bank_o), 0);
        chk("R1 reset offset", int'(offset_o), 0);
        chk("R1 reset src", int'(src_o), 1);
        rst_n = 1'b1;
        @(negedge clk);
        look(16'h0000);
        chk("R1 slot0 src", int'(src_o), 1);
        chk("R1 slot0 bank", int'(bank_o), 0);
        look(16'hC123);
        chk("R1 slot3 src", int'(src_o), 2);
        chk("R1 slot3 bank", int'(bank_o), 3);
        chk("R9 offset", int'(offset_o), 16'h0123);

        // R10: inputs change without the strobe
        load(8'd2, 1'b0, 1'b1, 8'd7);
        ram_cfg_i = 8'd7; lo_rom_map_i = 1'b1; hi_rom_map_i = 1'b0; rom_sel_i = 8'd0;
        @(negedge clk);
        look(16'h4000);
        chk("R10 held layout", int'(bank_o), 5);
        look(16'h0000);
        chk("R10 held lo flag", int'(src_o), 0);
        look(16'hFFFF);
        chk("R10 held sel", int'(src_o), 3);

        for (int b = 0; b < 2; b++) begin
            banked_i = b[0];
            for (int c = 0; c < 16; c++) begin
                for (int f = 0; f < 4; f++) begin
                    for (int si = 0; si < 5; si++) begin
                        logic [7:0] raw;
                        int lay;
                        raw = (c < 8) ? 8'(c) : (8'hF8 | 8'(c - 8));
                        lay = b ? (c % 8) : 0;
                        load(raw, f[0], f[1], sels[si]);
                        for (int sl = 0; sl < 4; sl++) begin
                            for (int k = 0; k < 2; k++) begin
                                logic [13:0] off;
                                int es;
                                off = (k == 0) ? 14'h3FFF : 14'((c * 613 + si * 97 + sl * 2741) & 16'h3FFF);
                                look({2'(sl), off});
                                if (c >= 8) chk("R3 bank high bits ignored", int'(bank_o), exp_bank(lay, sl));
                                else if (!b) chk("R4 base bank", int'(bank_o), exp_bank(lay, sl));
                                else chk("R2 bank", int'(bank_o), exp_bank(lay, sl));
                                chk("R9 offset", int'(offset_o), int'(off));
                                if (sl == 0) begin
                                    es = f[0] ? 1 : 0;
                                    chk("R5 slot0 src", int'(src_o), es);
                                end else if (sl == 3) begin
                                    es = f[1] ? ((b == 1 && sels[si] == 8'd7) ? 3 : 2) : 0;
                                    if (f[1]) chk("R7 upper rom pick", int'(src_o), es);
                                    else chk("R6 slot3 src", int'(src_o), es);
                                end else begin
                                    chk("R8 mid slot src", int'(src_o), 0);
                                end
                            end
                        end
                    end
                end
            end
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule